// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This block keeps the protection state of a serial flash array: a busy flag, a write-enable latch, a three-bit block-protect code and an enable bit that arms the external protect pin. A command front-end decodes the serial stream and hands the block single-cycle requests to set or clear the latch and to write the status byte, along with a chip-select level. The block answers with the byte to shift out on a status read and, for any array address the front-end presents, whether that address is locked against program or erase.

A status write is accepted into a pending slot while chip select is active. Its self-timed cycle starts once chip select is released. The cycle holds busy for a parameter-set number of clocks and then commits the protect-pin enable and the block-protect code. The protect pin can cancel the pending write before the cycle starts, but has no effect once the cycle is running.

Top module: `sr_wp_unit`

## Requirements
- R1: After reset the status byte reads 0x00: busy (bit 0) clear, write-enable latch (bit 1) clear, block-protect code (bits 4:2) 000 and protect-pin enable (bit 7) 0.
- R2: A set request sets the latch and a clear request clears it. When both arrive in the same cycle, clear wins. Clear works at either level of the protect pin.
- R3: A status write request made while the latch is clear is ignored: no busy cycle occurs and the status byte is unchanged.
- R4: When the protect pin is low and the enable bit is 1, a status write request is rejected. When the enable bit is 0, the pin level has no effect on status writes.
- R5: If the pin goes low while a write is pending and chip select is still active, and the enable bit is 1, the write is cancelled. Once the cycle has started, the pin has no effect.
- R6: An accepted write starts its cycle on the first clock where chip select is inactive. The status byte then reads 0xFF for WR_CYCLES clocks. After that it reads the new enable bit (bit 7) and code (bits 4:2), with the latch clear and bits 6, 5 and 0 reading 0.
- R7: While busy, set, clear and status write requests are ignored.
- R8: The lock decision for an address with upper three bits u is as follows. Code 000 locks nothing. Code 001 locks u = 7 (top 1/8). Code 010 locks u >= 6 (top 1/4). Code 011 locks u >= 4 (top 1/2). Any code 1xx locks every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_pin_ni | input | 1 | External protect pin, active low |
| sel_i | input | 1 | Chip select active (1 = selected) |
| req_wen_set_i | input | 1 | Pulse: set write-enable latch |
| req_wen_clr_i | input | 1 | Pulse: clear write-enable latch |
| req_sr_wr_i | input | 1 | Pulse: status write with sr_wdata_i |
| sr_wdata_i | input | 8 | Status byte to write (bits 7, 4:2 used) |
| chk_addr_i | input | ADDR_W | Array address to judge |
| locked_o | output | 1 | Address is locked by the protect code |
| status_o | output | 8 | Byte returned on a status read |

## Verification
Two collisions matter most. The first is a pin edge landing on a pending write before chip select releases, against one landing inside a running cycle. The bench provokes both and judges them by whether busy (0xFF) appears and by the final status byte. The second is a latch or write request arriving while the internal cycle is busy. The bench issues such requests mid-cycle and checks that the committed byte and the cleared latch after the cycle match a bench model, not the late requests.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;
  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_WEL  = 1;
  localparam int unsigned ST_BP_LO = 2;
  localparam int unsigned ST_BP_HI = 4;
  localparam int unsigned ST_PEN  = 7;
  localparam int unsigned BP_W    = 3;
  localparam logic [7:0]  ST_BUSY_BYTE = 8'hFF;

  typedef struct packed {
    logic            pen;
    logic [BP_W-1:0] bp;
  } prot_cfg_t;
endpackage

// File: rtl/sr_wp_lockout.sv
module sr_wp_lockout
  import sr_wp_pkg::*;
#(
  parameter int unsigned ADDR_W = 19
) (
  input  logic [BP_W-1:0]   bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  // level k (1..3) locks the top 2^-(4-k) of the array
  logic [3:1] lvl_hit;
  for (genvar k = 1; k <= 3; k++) begin : g_lvl
    localparam int unsigned TOPB = 4 - k;
    assign lvl_hit[k] = (bp_i[1:0] == 2'(k)) && (&addr_i[ADDR_W-1 -: TOPB]);
  end

  assign locked_o = bp_i[2] | (|lvl_hit);
endmodule

// File: rtl/sr_wp_timer.sv
module sr_wp_timer #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end
  end
endmodule

// File: rtl/sr_wp_unit.sv
module sr_wp_unit
  import sr_wp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned WR_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_pin_ni,
  input  logic              sel_i,
  input  logic              req_wen_set_i,
  input  logic              req_wen_clr_i,
  input  logic              req_sr_wr_i,
  input  logic [7:0]        sr_wdata_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              locked_o,
  output logic [7:0]        status_o
);
  logic            wel_q, wpen_q, pend_q;
  logic [BP_W-1:0] bp_q;
  prot_cfg_t       pend_cfg_q;
  logic            busy_w, done_w, hw_lock, start_w, accept_w;
  logic            unused_wdata;

  assign unused_wdata = ^{sr_wdata_i[6:5], sr_wdata_i[1:0]};

  assign hw_lock  = !prot_pin_ni && wpen_q;
  assign accept_w = req_sr_wr_i && sel_i && wel_q && !busy_w && !hw_lock;
  assign start_w  = pend_q && !sel_i && !hw_lock && !busy_w;

  sr_wp_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_w),
    .busy_o (busy_w),
    .done_o (done_w)
  );

  sr_wp_lockout #(.ADDR_W(ADDR_W)) u_lock (
    .bp_i    (bp_q),
    .addr_i  (chk_addr_i),
    .locked_o(locked_o)
  );

  // pending slot: filled under select, dropped on pin lock or on start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_cfg_q <= '0;
    end else if (accept_w) begin
      pend_q     <= 1'b1;
      pend_cfg_q <= '{pen: sr_wdata_i[ST_PEN], bp: sr_wdata_i[ST_BP_HI:ST_BP_LO]};
    end else if (pend_q && (hw_lock || start_w)) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q  <= 1'b0;
      wpen_q <= 1'b0;
      bp_q   <= '0;
    end else if (done_w) begin
      wel_q  <= 1'b0;
      wpen_q <= pend_cfg_q.pen;
      bp_q   <= pend_cfg_q.bp;
    end else if (!busy_w) begin
      if (req_wen_clr_i)      wel_q <= 1'b0;
      else if (req_wen_set_i) wel_q <= 1'b1;
    end
  end

  always_comb begin
    status_o = '0;
    if (busy_w) begin
      status_o = ST_BUSY_BYTE;
    end else begin
      status_o[ST_PEN]             = wpen_q;
      status_o[ST_BP_HI:ST_BP_LO]  = bp_q;
      status_o[ST_WEL]             = wel_q;
    end
  end
endmodule

// File: rtl/sr_wp_chk.sv
module sr_wp_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prot_pin_ni,
  input logic       req_wen_clr_i,
  input logic       busy,
  input logic       done,
  input logic       wel,
  input logic       wpen,
  input logic [2:0] bp,
  input logic       locked_o,
  input logic [7:0] status_o
);
  // R6: status reads all ones while the timer runs
  a_r6_ff_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> status_o == 8'hFF);

  // R6: configuration changes only at the end of a cycle
  a_r6_cfg_only_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> ($stable(bp) && $stable(wpen)));

  // R6: completion clears the latch
  a_r6_done_clears_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !wel);

  // R7: latch frozen inside a cycle
  a_r7_wel_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> $stable(wel));

  // R2: clear request when idle always clears
  a_r2_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_wen_clr_i && !busy) |=> !wel);

  // R4: pin lock forbids a cycle start
  a_r4_no_start_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prot_pin_ni && wpen && !busy) |=> !busy);

  // R8: any code 1xx locks every address
  a_r8_all_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp[2] |-> locked_o);
endmodule

bind sr_wp_unit sr_wp_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .prot_pin_ni  (prot_pin_ni),
  .req_wen_clr_i(req_wen_clr_i),
  .busy         (busy_w),
  .done         (done_w),
  .wel          (wel_q),
  .wpen         (wpen_q),
  .bp           (bp_q),
  .locked_o     (locked_o),
  .status_o     (status_o)
);

// File: tb/sr_wp_unit_tb.sv
module sr_wp_unit_tb;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned ADDR_W     = 19;
  localparam int unsigned WR_CYCLES  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_n = 1'b1, sel = 1'b0, wset = 1'b0, wclr = 1'b0, srwr = 1'b0;
  logic [7:0] wdata = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic locked;
  logic [7:0] status;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  logic       m_pen = 1'b0;
  logic [2:0] m_bp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_wp_unit #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .prot_pin_ni(pin_n), .sel_i(sel),
    .req_wen_set_i(wset), .req_wen_clr_i(wclr), .req_sr_wr_i(srwr),
    .sr_wdata_i(wdata), .chk_addr_i(addr), .locked_o(locked), .status_o(status)
  );

  function automatic logic [7:0] exp_status(logic pen, logic [2:0] bp, logic wel);
    return {pen, 2'b00, bp, wel, 1'b0};
  endfunction

  function automatic logic exp_lock(logic [2:0] bp, logic [ADDR_W-1:0] a);
    logic [2:0] u = a[ADDR_W-1 -: 3];
    if (bp[2]) return 1'b1;
    case (bp[1:0])
      2'd1: return u == 3'd7;
      2'd2: return u >= 3'd6;
      2'd3: return u >= 3'd4;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_set();
    @(negedge clk); wset = 1'b1; @(negedge clk); wset = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); wclr = 1'b1; @(negedge clk); wclr = 1'b0;
  endtask

  // write under select, release select; leaves at the negedge where select dropped
  task automatic sr_write(logic [7:0] d);
    @(negedge clk); sel = 1'b1; srwr = 1'b1; wdata = d;
    @(negedge clk); srwr = 1'b0;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic expect_cycle(string req, logic [7:0] d);
    for (int i = 0; i < WR_CYCLES; i++) begin
      @(negedge clk);
      if (i == 0 || i == WR_CYCLES - 1) chk8(req, status, 8'hFF);
    end
    @(negedge clk);
    m_pen = d[7]; m_bp = d[4:2];
    chk8(req, status, exp_status(m_pen, m_bp, 1'b0));
  endtask

  task automatic check_addrs(int n);
    for (int i = 0; i < n; i++) begin
      addr = ADDR_W'($urandom);
      #1;
      chk8("R8 lock", {7'd0, locked}, {7'd0, exp_lock(m_bp, addr)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    chk8("R1 reset", status, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk8("R1 after release", status, 8'h00);

    // R2 set, clear, simultaneous, clear with pin low
    pulse_set();  chk8("R2 set", status, 8'h02);
    pulse_clr();  chk8("R2 clr", status, 8'h00);
    pulse_set();
    @(negedge clk); wset = 1'b1; wclr = 1'b1;
    @(negedge clk); wset = 1'b0; wclr = 1'b0;
    chk8("R2 clear wins", status, 8'h00);

    // R3 write without latch ignored
    sr_write(8'h9C);
    @(negedge clk); chk8("R3 no latch", status, 8'h00);
    @(negedge clk); chk8("R3 no latch later", status, 8'h00);

    // R4 enable bit 0: pin low ignored; R6 cycle
    pin_n = 1'b0;
    pulse_set();
    sr_write(8'hEC);        // pen=1 bp=011, bits 6,5 set in data
    expect_cycle("R4/R6 pen0 pin low", 8'hEC);
    chk8("R6 unused bits zero", status & 8'h61, 8'h00);
    check_addrs(20);

    // R4 now locked: pin low + enable 1
    pulse_clr(); pulse_set();
    chk8("R2 clr/set pin low", status, exp_status(m_pen, m_bp, 1'b1));
    sr_write(8'h00);
    @(negedge clk); @(negedge clk);
    chk8("R4 hw lock rejects", status, exp_status(m_pen, m_bp, 1'b1));
    pulse_clr();
    chk8("R2 clr with hw lock", status, exp_status(m_pen, m_bp, 1'b0));

    // R5 cancel: pin drops while pending under select
    pin_n = 1'b1;
    pulse_set();
    @(negedge clk); sel = 1'b1; srwr = 1'b1; wdata = 8'h04;
    @(negedge clk); srwr = 1'b0; pin_n = 1'b0;
    @(negedge clk); pin_n = 1'b1;
    @(negedge clk); sel = 1'b0;
    @(negedge clk); chk8("R5 cancel", status, exp_status(m_pen, m_bp, 1'b1));
    @(negedge clk); chk8("R5 cancel stays", status, exp_status(m_pen, m_bp, 1'b1));

    // R5 pin after start has no effect; R7 requests during busy ignored
    sr_write(8'h08);
    @(negedge clk); pin_n = 1'b0; wset = 1'b1;
    chk8("R5 busy", status, 8'hFF);
    @(negedge clk); wset = 1'b0; sel = 1'b1; srwr = 1'b1; wdata = 8'h90;
    @(negedge clk); srwr = 1'b0; sel = 1'b0;
    for (int i = 3; i < WR_CYCLES; i++) @(negedge clk);
    chk8("R7 still busy", status, 8'hFF);
    @(negedge clk);
    m_pen = 1'b0; m_bp = 3'b010;
    chk8("R5/R7 commit", status, exp_status(m_pen, m_bp, 1'b0));
    repeat (3) @(negedge clk);
    chk8("R7 no late cycle", status, exp_status(m_pen, m_bp, 1'b0));
    pin_n = 1'b1;
    check_addrs(20);

    // random attempts
    for (int it = 0; it < 40; it++) begin
      logic do_wen = 1'($urandom);
      logic pin    = 1'($urandom);
      logic [7:0] d = 8'($urandom);
      pin_n = 1'b1;
      if (do_wen) pulse_set();
      pin_n = pin;
      sr_write(d);
      if (do_wen && !(!pin && m_pen)) begin
        expect_cycle(do_wen ? "R6 random commit" : "R3", d);
      end else begin
        @(negedge clk); @(negedge clk);
        chk8(do_wen ? "R4 random reject" : "R3 random ignore",
             status, exp_status(m_pen, m_bp, do_wen));
        pulse_clr();
      end
      check_addrs(4);
    end

    // R8 directed codes at boundaries
    for (int c = 0; c < 5; c++) begin
      logic [2:0] code = (c == 4) ? 3'b100 : 3'(c);
      pin_n = 1'b1;
      pulse_set();
      sr_write({5'b0, code, 2'b0} >> 0 == 0 ? 8'h00 : {3'b000, code, 2'b00});
      expect_cycle("R8 set code", {3'b000, code, 2'b00});
      for (int u = 0; u < 8; u++) begin
        addr = {3'(u), {(ADDR_W-3){1'b1}}};
        #1;
        chk8("R8 boundary", {7'd0, locked}, {7'd0, exp_lock(m_bp, addr)});
        addr = {3'(u), {(ADDR_W-3){1'b0}}};
        #1;
        chk8("R8 boundary low", {7'd0, locked}, {7'd0, exp_lock(m_bp, addr)});
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule